// File: doc/BRIEF.md
# DMA Remapping Page Table Walker

This block turns one 4 KiB-aligned device DMA address into a physical page by walking a multi-level page table that lives in memory. A request carries the input address, the wanted read/write rights, the base of the top-level table, the number of paging levels and a mode flag that selects between legacy and scalable fault reporting. The walker then reads one 64-bit table entry per level over a simple request/response memory port, checks each entry, and stops either at a 4 KiB leaf, at a permitted large page, or at the first fault.

At the end of a walk it reports the page base, the page shift and the rights that the final entry grants. If the walk fails it reports a fault and a reason code, and the code depends on the mode. Entry format: bit 0 grants read, bit 1 grants write, bit 7 marks a large page, and bits 51:12 hold the next table or page address. Bits 63:52, 11:8 and 6:2 are reserved. A caller pulses `start` while the block is idle and waits for the one-cycle `done`.

Top module: `slpt_walker`

## Requirements
- R1: Only depths 3, 4 and 5 are walked. The walk begins at level depth-1, performs exactly one entry read per level and moves down one level at a time to level 0. Any other depth ends the walk with the address-width fault code (1 legacy, 2 scalable) and no read.
- R2: If any input address bit at or above the GAW parameter (default 48) is set, the block faults before any memory read. The code is 1 in legacy mode and 2 in scalable mode. Bit GAW-1 is still accepted.
- R3: At level L the entry is read from table base + 8 × ((address >> (12 + 9·L)) & 0x1FF). The top table base is `rootPtr`. A lower table base is the entry with everything except bits 51:12 cleared.
- R4: An entry passes only when (entry bits 1:0 & requested rights) equals the requested rights, where bit 0 is read and bit 1 is write. On failure the code is 5 in legacy mode and 6 in scalable mode. This covers a non-present entry, whose rights are 00.
- R5: An entry with any reserved bit set (63:52, 11:8 or 6:2) faults with code 5 in legacy mode and 7 in scalable mode. This check runs after the rights check.
- R6: When bit 7 is set at a level L above 0, the walk ends as a large page if bit L-1 of the LARGE_CAP parameter (default 4'b0011) is set. The shift is 12 + 9·L and the base is the entry's address field with its low shift bits cleared. If the capability bit is clear, the walk faults with code 5 in legacy mode and 7 in scalable mode.
- R7: At level 0 the entry is a 4 KiB leaf and bit 7 is ignored there. The base is entry bits 51:12 followed by 12 zero bits, and the shift is 12. The granted rights are bits 1:0 of the final entry.
- R8: If the resulting base lies in [IRQ_WIN_BASE, IRQ_WIN_BASE+IRQ_WIN_SIZE), with defaults 0xFEE00000 and 0x100000, the walk faults with code 8 in legacy mode and 9 in scalable mode.
- R9: An error response to an entry read faults with code 3 in legacy mode and 4 in scalable mode.
- R10: At most one read is outstanding at a time. `memReqValid` is a one-cycle pulse, and no further request is issued until the response to the previous one arrives.
- R11: `start` is taken only while `busy` is low. `busy` stays high from the cycle after a taken start through the `done` cycle, and `done` lasts one cycle. The results hold until the next start. On a fault, base, shift and rights are zero, while a success reports code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (taken when idle) |
| reqAddr | input | 64 | Input DMA address |
| reqPerm | input | 2 | Requested rights, bit 0 read, bit 1 write |
| rootPtr | input | 64 | Base of the top-level table |
| depth | input | 3 | Number of paging levels |
| scalable | input | 1 | 1 selects scalable fault codes, 0 legacy |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion strobe |
| fault | output | 1 | Walk ended in a fault |
| faultCode | output | 4 | Fault reason, 0 on success |
| outBase | output | 64 | Output page base |
| outShift | output | 6 | Output page shift |
| outPerm | output | 2 | Rights of the final entry |
| memReqValid | output | 1 | Entry read request pulse |
| memReqAddr | output | 64 | Entry read address |
| memRspValid | input | 1 | Read response valid |
| memRspData | input | 64 | Read response entry |
| memRspErr | input | 1 | Read response error |

## Verification
A small table set in a bench memory is walked with rights requests that are either met or refused by the final or an intermediate entry. This separates the rights check from the rights that the walker reports back. Large-page entries at levels 1, 2 and 3 separate a permitted from a refused capability bit. Leaf bases just inside, just below and just above the interrupt window pin down the window bounds. Each fault case runs in both modes so that shared and distinct reason codes are told apart, and depths 2 through 6 together with address bits 47 and 50 probe both edges of the level and width rules.

// File: rtl/slpt_pkg.sv
package slpt_pkg;
  localparam int ADDR_W     = 64;
  localparam int LVL_BITS   = 9;
  localparam int PAGE_SHIFT = 12;
  localparam int MAX_LEVELS = 5;
  localparam int LVL_W      = 3;
  localparam int SHIFT_W    = 6;
  localparam int PERM_W     = 2;

  typedef enum logic [3:0] {
    FC_NONE       = 4'd0,
    FC_WIDTH_LEG  = 4'd1,
    FC_WIDTH_SCL  = 4'd2,
    FC_READ_LEG   = 4'd3,
    FC_READ_SCL   = 4'd4,
    FC_ENTRY_LEG  = 4'd5,
    FC_PERM_SCL   = 4'd6,
    FC_RSVD_SCL   = 4'd7,
    FC_WINDOW_LEG = 4'd8,
    FC_WINDOW_SCL = 4'd9
  } faultCode_e;

  typedef struct packed {
    logic       load;
    logic       capture;
    logic       descend;
    logic       finish;
    logic       finFault;
    faultCode_e code;
  } ctrlStrobe_t;

  typedef struct packed {
    logic widthBad;
    logic depthBad;
    logic permBad;
    logic rsvdBad;
    logic isLarge;
    logic largeOk;
    logic atLeaf;
    logic inWindow;
  } dpStatus_t;
endpackage

// File: rtl/slpt_dpath.sv
module slpt_dpath
  import slpt_pkg::*;
#(
  parameter int                     GAW          = 48,
  parameter logic [ADDR_W-1:0]      IRQ_WIN_BASE = 64'h0000_0000_FEE0_0000,
  parameter logic [ADDR_W-1:0]      IRQ_WIN_SIZE = 64'h0000_0000_0010_0000,
  parameter logic [MAX_LEVELS-2:0]  LARGE_CAP    = 4'b0011
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctrlStrobe_t          strobe,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [PERM_W-1:0]    reqPerm,
  input  logic [ADDR_W-1:0]    rootPtr,
  input  logic [LVL_W-1:0]     depth,
  input  logic [ADDR_W-1:0]    memRspData,
  output dpStatus_t            status,
  output logic [ADDR_W-1:0]    memReqAddr,
  output logic                 resFault,
  output faultCode_e           resCode,
  output logic [ADDR_W-1:0]    resBase,
  output logic [SHIFT_W-1:0]   resShift,
  output logic [PERM_W-1:0]    resPerm
);
  localparam logic [ADDR_W-1:0] WIDTH_MASK = ~((64'd1 << GAW) - 64'd1);
  localparam logic [ADDR_W-1:0] RSVD_MASK  = 64'hFFF0_0000_0000_0F7C;
  localparam logic [ADDR_W-1:0] ADDR_FIELD = 64'h000F_FFFF_FFFF_F000;
  localparam int                PS_BIT     = 7;

  logic [ADDR_W-1:0]  vaddr;
  logic [PERM_W-1:0]  permQ;
  logic [ADDR_W-1:0]  tablePtr;
  logic [LVL_W-1:0]   level;
  logic [LVL_W-1:0]   depthQ;
  logic [ADDR_W-1:0]  entryQ;

  logic [SHIFT_W-1:0]    shiftCur;
  logic [ADDR_W-1:0]     shiftedAddr;
  logic [LVL_BITS-1:0]   idx;
  logic [ADDR_W-1:0]     leafBase;
  logic [MAX_LEVELS-2:0] capShifted;

  always_comb begin
    shiftCur    = SHIFT_W'(PAGE_SHIFT) + SHIFT_W'(level) * SHIFT_W'(LVL_BITS);
    shiftedAddr = vaddr >> shiftCur;
    idx         = shiftedAddr[LVL_BITS-1:0];
    memReqAddr  = tablePtr + {{(ADDR_W-LVL_BITS-3){1'b0}}, idx, 3'b000};
    leafBase    = entryQ & ADDR_FIELD & ~((64'd1 << shiftCur) - 64'd1);
    capShifted  = LARGE_CAP >> (level - LVL_W'(1));

    status.widthBad = |(vaddr & WIDTH_MASK);
    status.depthBad = (depthQ < LVL_W'(3)) || (depthQ > LVL_W'(MAX_LEVELS));
    status.permBad  = (entryQ[PERM_W-1:0] & permQ) != permQ;
    status.rsvdBad  = |(entryQ & RSVD_MASK);
    status.atLeaf   = (level == '0);
    status.isLarge  = entryQ[PS_BIT] && (level != '0);
    status.largeOk  = (level != '0) && capShifted[0];
    status.inWindow = (leafBase - IRQ_WIN_BASE) < IRQ_WIN_SIZE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddr    <= '0;
      permQ    <= '0;
      tablePtr <= '0;
      level    <= '0;
      depthQ   <= '0;
      entryQ   <= '0;
    end else begin
      if (strobe.load) begin
        vaddr    <= reqAddr;
        permQ    <= reqPerm;
        tablePtr <= rootPtr;
        depthQ   <= depth;
        level    <= depth - LVL_W'(1);
      end
      if (strobe.capture) entryQ <= memRspData;
      if (strobe.descend) begin
        tablePtr <= entryQ & ADDR_FIELD;
        level    <= level - LVL_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resFault <= 1'b0;
      resCode  <= FC_NONE;
      resBase  <= '0;
      resShift <= '0;
      resPerm  <= '0;
    end else if (strobe.finish) begin
      resFault <= strobe.finFault;
      resCode  <= strobe.finFault ? strobe.code : FC_NONE;
      resBase  <= strobe.finFault ? '0 : leafBase;
      resShift <= strobe.finFault ? '0 : shiftCur;
      resPerm  <= strobe.finFault ? '0 : entryQ[PERM_W-1:0];
    end
  end

  // R1: every descent lowers the level by exactly one
  p_level_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.descend |=> level == $past(level) - LVL_W'(1));

  // R3: the next table pointer is page aligned after a descent
  p_table_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.descend |=> tablePtr[PAGE_SHIFT-1:0] == '0);
endmodule

// File: rtl/slpt_ctrl.sv
module slpt_ctrl
  import slpt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        scalable,
  input  dpStatus_t   status,
  input  logic        memRspValid,
  input  logic        memRspErr,
  output ctrlStrobe_t strobe,
  output logic        memReqValid,
  output logic        busy,
  output logic        done
);
  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_ISSUE, S_WAIT, S_EVAL, S_DONE
  } state_e;

  state_e state, stateNext;
  logic   modeQ;

  function automatic faultCode_e pick(input logic scl, input faultCode_e legCode,
                                      input faultCode_e sclCode);
    return scl ? sclCode : legCode;
  endfunction

  always_comb begin
    stateNext   = state;
    strobe      = '0;
    strobe.code = FC_NONE;
    memReqValid = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        strobe.load = 1'b1;
        stateNext   = S_CHECK;
      end
      S_CHECK: begin
        if (status.depthBad || status.widthBad) begin
          strobe.finish   = 1'b1;
          strobe.finFault = 1'b1;
          strobe.code     = pick(modeQ, FC_WIDTH_LEG, FC_WIDTH_SCL);
          stateNext       = S_DONE;
        end else begin
          stateNext = S_ISSUE;
        end
      end
      S_ISSUE: begin
        memReqValid = 1'b1;
        stateNext   = S_WAIT;
      end
      S_WAIT: if (memRspValid) begin
        if (memRspErr) begin
          strobe.finish   = 1'b1;
          strobe.finFault = 1'b1;
          strobe.code     = pick(modeQ, FC_READ_LEG, FC_READ_SCL);
          stateNext       = S_DONE;
        end else begin
          strobe.capture = 1'b1;
          stateNext      = S_EVAL;
        end
      end
      S_EVAL: begin
        stateNext = S_DONE;
        if (status.permBad) begin
          strobe.finish   = 1'b1;
          strobe.finFault = 1'b1;
          strobe.code     = pick(modeQ, FC_ENTRY_LEG, FC_PERM_SCL);
        end else if (status.rsvdBad || (status.isLarge && !status.largeOk)) begin
          strobe.finish   = 1'b1;
          strobe.finFault = 1'b1;
          strobe.code     = pick(modeQ, FC_ENTRY_LEG, FC_RSVD_SCL);
        end else if (status.isLarge || status.atLeaf) begin
          strobe.finish   = 1'b1;
          strobe.finFault = status.inWindow;
          strobe.code     = status.inWindow ? pick(modeQ, FC_WINDOW_LEG, FC_WINDOW_SCL)
                                            : FC_NONE;
        end else begin
          strobe.descend = 1'b1;
          stateNext      = S_ISSUE;
        end
      end
      S_DONE:  stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      modeQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobe.load) modeQ <= scalable;
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

  // R10: a request is a single-cycle pulse
  p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid |=> !memReqValid);

  // R11: done lasts one cycle and returns the block to idle
  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R2: an over-wide address finishes without any read
  p_width_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CHECK && status.widthBad) |=> (done && !memReqValid));
endmodule

// File: rtl/slpt_walker.sv
module slpt_walker
  import slpt_pkg::*;
#(
  parameter int                     GAW          = 48,
  parameter logic [ADDR_W-1:0]      IRQ_WIN_BASE = 64'h0000_0000_FEE0_0000,
  parameter logic [ADDR_W-1:0]      IRQ_WIN_SIZE = 64'h0000_0000_0010_0000,
  parameter logic [MAX_LEVELS-2:0]  LARGE_CAP    = 4'b0011
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [63:0] reqAddr,
  input  logic [1:0]  reqPerm,
  input  logic [63:0] rootPtr,
  input  logic [2:0]  depth,
  input  logic        scalable,
  output logic        busy,
  output logic        done,
  output logic        fault,
  output logic [3:0]  faultCode,
  output logic [63:0] outBase,
  output logic [5:0]  outShift,
  output logic [1:0]  outPerm,
  output logic        memReqValid,
  output logic [63:0] memReqAddr,
  input  logic        memRspValid,
  input  logic [63:0] memRspData,
  input  logic        memRspErr
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;
  faultCode_e  resCode;

  slpt_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .scalable    (scalable),
    .status      (status),
    .memRspValid (memRspValid),
    .memRspErr   (memRspErr),
    .strobe      (strobe),
    .memReqValid (memReqValid),
    .busy        (busy),
    .done        (done)
  );

  slpt_dpath #(
    .GAW          (GAW),
    .IRQ_WIN_BASE (IRQ_WIN_BASE),
    .IRQ_WIN_SIZE (IRQ_WIN_SIZE),
    .LARGE_CAP    (LARGE_CAP)
  ) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .reqAddr    (reqAddr),
    .reqPerm    (reqPerm),
    .rootPtr    (rootPtr),
    .depth      (depth),
    .memRspData (memRspData),
    .status     (status),
    .memReqAddr (memReqAddr),
    .resFault   (fault),
    .resCode    (resCode),
    .resBase    (outBase),
    .resShift   (outShift),
    .resPerm    (outPerm)
  );

  assign faultCode = resCode;

  // R8: a successful result never lands in the interrupt window
  p_window_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> ((outBase - IRQ_WIN_BASE) >= IRQ_WIN_SIZE));

  // R7: a successful base is aligned to its own page size
  p_base_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> ((outBase & ((64'd1 << outShift) - 64'd1)) == '0));

  // R11: a fault clears base, shift and rights
  p_fault_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (outBase == '0 && outShift == '0 && outPerm == '0));
endmodule

// File: tb/slpt_walker_bench.sv
module slpt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] reqAddr = '0;
  logic [1:0]  reqPerm = '0;
  logic [63:0] rootPtr = '0;
  logic [2:0]  depth = '0;
  logic        scalable = 1'b0;
  logic        busy, done, fault;
  logic [3:0]  faultCode;
  logic [63:0] outBase;
  logic [5:0]  outShift;
  logic [1:0]  outPerm;
  logic        memReqValid;
  logic [63:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        memRspErr = 1'b0;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic        f;
    logic [3:0]  code;
    logic [63:0] base;
    logic [5:0]  shift;
    logic [1:0]  perm;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  logic [63:0] memData [logic [63:0]];
  bit          memErr  [logic [63:0]];

  always #4 clk = ~clk;

  slpt_walker u_slpt_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .reqAddr(reqAddr), .reqPerm(reqPerm),
    .rootPtr(rootPtr), .depth(depth), .scalable(scalable), .busy(busy), .done(done),
    .fault(fault), .faultCode(faultCode), .outBase(outBase), .outShift(outShift),
    .outPerm(outPerm), .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .memRspErr(memRspErr)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  // memory model: latency of two falling edges, one outstanding allowed
  bit          pending = 0;
  int          waitCnt = 0;
  logic [63:0] pAddr = '0;
  always @(negedge clk) begin
    memRspValid <= 1'b0;
    memRspErr   <= 1'b0;
    if (pending) begin
      if (waitCnt == 0) begin
        memRspValid <= 1'b1;
        memRspData  <= memData.exists(pAddr) ? memData[pAddr] : 64'h0;
        memRspErr   <= memErr.exists(pAddr);
        pending     <= 0;
      end else waitCnt <= waitCnt - 1;
    end
    if (memReqValid) begin
      check(!pending, "R10 request while outstanding", 64'(pending), 64'h0);
      check(memReqAddr[2:0] == 3'b0, "R3 entry address alignment", memReqAddr, 64'h0);
      pending <= 1;
      waitCnt <= 1;
      pAddr   <= memReqAddr;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (expQ.size() == 0) begin
        check(0, "R11 unexpected done", 64'h1, 64'h0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(fault == e.f,        {e.tag, " fault"}, 64'(fault), 64'(e.f));
        check(faultCode == e.code, {e.tag, " code"},  64'(faultCode), 64'(e.code));
        check(outBase == e.base,   {e.tag, " base"},  outBase, e.base);
        check(outShift == e.shift, {e.tag, " shift"}, 64'(outShift), 64'(e.shift));
        check(outPerm == e.perm,   {e.tag, " perm"},  64'(outPerm), 64'(e.perm));
      end
    end
  end

  function automatic logic [63:0] va(input int l3, input int l2, input int l1, input int l0);
    return (64'(l3) << 39) | (64'(l2) << 30) | (64'(l1) << 21) | (64'(l0) << 12);
  endfunction

  task automatic runReq(input logic [63:0] a, input logic [1:0] p, input logic [63:0] root,
                        input logic [2:0] d, input logic scl, input logic ef,
                        input logic [3:0] ec, input logic [63:0] eb, input logic [5:0] es,
                        input logic [1:0] ep, input string tag, input bit poke = 0);
    exp_t e;
    e.f = ef; e.code = ec; e.base = eb; e.shift = es; e.perm = ep; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    reqAddr = a; reqPerm = p; rootPtr = root; depth = d; scalable = scl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      reqAddr = 64'hFFFF_0000_0000_0000; depth = 3'd2; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    // table set
    memData[64'h1008] = 64'h2000 | 64'h3;
    memData[64'h1800] = 64'h2000 | 64'h3;
    memData[64'h1010] = 64'h83;
    memData[64'h2010] = 64'h3000 | 64'h3;
    memData[64'h2018] = 64'h40_0000_0000 | 64'h81;
    memData[64'h2020] = 64'h3000;
    memData[64'h3018] = 64'h4000 | 64'h3;
    memData[64'h3030] = 64'h4_0020_5000 | 64'h83;
    memData[64'h4020] = 64'h12_3456_7000 | 64'h3;
    memData[64'h4028] = 64'h88_8888_8000 | 64'h1;
    memData[64'h4040] = 64'h9000 | 64'h3 | (64'h1 << 60);
    memData[64'h4058] = 64'h9000 | 64'h3 | 64'h4;
    memErr [64'h4048] = 1;
    memData[64'h4050] = 64'hFEE0_0000 | 64'h3;
    memData[64'h4060] = 64'hFEF0_0000 | 64'h3;
    memData[64'h4068] = 64'hFEDF_F000 | 64'h3;
    memData[64'h5008] = 64'h6000 | 64'h3;
    memData[64'h6000] = 64'h4000 | 64'h3;
    memData[64'h7000] = 64'h1000 | 64'h3;

    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0, "R11 reset idle", 64'({busy, done}), 64'h0);
    check(memReqValid == 0, "R10 reset no request", 64'(memReqValid), 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    runReq(va(1,2,3,4), 2'b11, 64'h1000, 3'd4, 0, 0, 4'd0, 64'h12_3456_7000, 6'd12, 2'b11, "R1 R3 R7 four-level leaf");
    runReq(va(1,2,3,4), 2'b11, 64'h1000, 3'd4, 1, 0, 4'd0, 64'h12_3456_7000, 6'd12, 2'b11, "R7 leaf scalable");
    runReq(va(1,2,3,5), 2'b01, 64'h1000, 3'd4, 0, 0, 4'd0, 64'h88_8888_8000, 6'd12, 2'b01, "R7 final rights read-only");
    runReq(va(1,2,3,5), 2'b10, 64'h1000, 3'd4, 0, 1, 4'd5, 64'h0, 6'd0, 2'b00, "R4 write refused legacy");
    runReq(va(1,2,3,5), 2'b10, 64'h1000, 3'd4, 1, 1, 4'd6, 64'h0, 6'd0, 2'b00, "R4 write refused scalable");
    runReq(va(1,4,0,0), 2'b01, 64'h1000, 3'd4, 0, 1, 4'd5, 64'h0, 6'd0, 2'b00, "R4 non-present middle entry");
    runReq(va(1,2,6,7), 2'b11, 64'h1000, 3'd4, 0, 0, 4'd0, 64'h4_0020_0000, 6'd21, 2'b11, "R6 2M page");
    runReq(va(1,3,0,0), 2'b01, 64'h1000, 3'd4, 1, 0, 4'd0, 64'h40_0000_0000, 6'd30, 2'b01, "R6 1G page");
    runReq(va(2,0,0,0), 2'b01, 64'h1000, 3'd4, 0, 1, 4'd5, 64'h0, 6'd0, 2'b00, "R6 level3 large refused legacy");
    runReq(va(2,0,0,0), 2'b01, 64'h1000, 3'd4, 1, 1, 4'd7, 64'h0, 6'd0, 2'b00, "R6 level3 large refused scalable");
    runReq(va(1,2,3,8), 2'b01, 64'h1000, 3'd4, 0, 1, 4'd5, 64'h0, 6'd0, 2'b00, "R5 reserved high legacy");
    runReq(va(1,2,3,8), 2'b01, 64'h1000, 3'd4, 1, 1, 4'd7, 64'h0, 6'd0, 2'b00, "R5 reserved high scalable");
    runReq(va(1,2,3,11), 2'b01, 64'h1000, 3'd4, 1, 1, 4'd7, 64'h0, 6'd0, 2'b00, "R5 reserved bit2 scalable");
    runReq(va(1,2,3,4) | (64'h1 << 50), 2'b01, 64'h1000, 3'd4, 0, 1, 4'd1, 64'h0, 6'd0, 2'b00, "R2 wide address legacy");
    runReq(va(1,2,3,4) | (64'h1 << 50), 2'b01, 64'h1000, 3'd4, 1, 1, 4'd2, 64'h0, 6'd0, 2'b00, "R2 wide address scalable");
    runReq(va(256,2,3,4), 2'b11, 64'h1000, 3'd4, 0, 0, 4'd0, 64'h12_3456_7000, 6'd12, 2'b11, "R2 bit47 accepted");
    runReq(va(1,2,3,9), 2'b01, 64'h1000, 3'd4, 0, 1, 4'd3, 64'h0, 6'd0, 2'b00, "R9 read error legacy");
    runReq(va(1,2,3,9), 2'b01, 64'h1000, 3'd4, 1, 1, 4'd4, 64'h0, 6'd0, 2'b00, "R9 read error scalable");
    runReq(va(1,2,3,10), 2'b01, 64'h1000, 3'd4, 0, 1, 4'd8, 64'h0, 6'd0, 2'b00, "R8 window legacy");
    runReq(va(1,2,3,10), 2'b01, 64'h1000, 3'd4, 1, 1, 4'd9, 64'h0, 6'd0, 2'b00, "R8 window scalable");
    runReq(va(1,2,3,12), 2'b01, 64'h1000, 3'd4, 0, 0, 4'd0, 64'hFEF0_0000, 6'd12, 2'b11, "R8 just above window");
    runReq(va(1,2,3,13), 2'b01, 64'h1000, 3'd4, 1, 0, 4'd0, 64'hFEDF_F000, 6'd12, 2'b11, "R8 just below window");
    runReq(64'h4000_4000, 2'b11, 64'h5000, 3'd3, 0, 0, 4'd0, 64'h12_3456_7000, 6'd12, 2'b11, "R1 depth 3");
    runReq(va(1,2,3,4), 2'b11, 64'h7000, 3'd5, 0, 0, 4'd0, 64'h12_3456_7000, 6'd12, 2'b11, "R1 depth 5");
    runReq(va(1,2,3,4), 2'b11, 64'h1000, 3'd2, 0, 1, 4'd1, 64'h0, 6'd0, 2'b00, "R1 depth 2 refused");
    runReq(va(1,2,3,4), 2'b11, 64'h1000, 3'd6, 1, 1, 4'd2, 64'h0, 6'd0, 2'b00, "R1 depth 6 refused");
    runReq(va(1,2,3,4), 2'b11, 64'h1000, 3'd4, 0, 0, 4'd0, 64'h12_3456_7000, 6'd12, 2'b11, "R11 start while busy ignored", 1);

    check(busy == 0, "R11 no second walk after ignored start", 64'(busy), 64'h0);
    check(outBase == 64'h12_3456_7000, "R11 result held", outBase, 64'h12_3456_7000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL R11 watchdog expired actual=busy expected=idle");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule